// File: doc/BRIEF.md
# CAN Receive Acceptance Filter and Buffer Selector

This block picks the message buffer that should take an incoming CAN frame. It holds sixteen filter entries. Each entry has an acceptance code, a frame-kind bit (standard or extended), a valid bit and a bit that chooses one of two shared mask registers. When the receiver presents a decoded identifier with a strobe, every valid entry compares the identifier with its code. The comparison skips the bit positions that its chosen mask marks as don't-care. The lowest-numbered entry that accepts the frame is reported as the store target.

Software-side register writes arrive on plain write ports: one entry's code and kind at a time, the mask-select and valid vectors as whole words, and either mask register. The decision is registered and stays on the outputs until the next receive strobe, so the storage logic downstream can read it at its own pace. Masks should only be changed while every entry that uses them is invalid.

Top module: `canrx_filter_select`

## Requirements
- R1: After a synchronous reset `hit` is 0 and `hit_idx` is 0. All entries are invalid, all mask-select bits are 0 and both masks are zero, so no frame is accepted until software sets an entry valid.
- R2: A mask bit of 0 requires the received identifier bit to equal the entry code bit. A mask bit of 1 makes that position don't-care.
- R3: If any compared bit differs, that entry rejects the frame.
- R4: When several entries accept a frame, `hit_idx` is the lowest entry number among them, from 0 to 15.
- R5: An entry whose valid bit is 0 never accepts a frame.
- R6: Mask-select bit n set to 0 makes entry n use mask register 0 (written with `mask_wr_sel`=0). Set to 1, it makes entry n use mask register 1.
- R7: `rx_ext`=0 marks a standard frame. For a standard frame only identifier bits [28:18] are compared, and bits [17:0] are ignored. `rx_ext`=1 marks an extended frame, and all 29 bits are compared. In both cases an entry accepts only if its kind bit (`id_wr_ext` when written) equals `rx_ext`.
- R8: The result appears on `hit`/`hit_idx` at the first clock edge after the edge that samples `rx_strobe` high. It is held unchanged until the next strobe. On a miss, `hit` is 0 and `hit_idx` is 0.
- R9: A register write in the same cycle as `rx_strobe` does not affect that frame's decision. Only later frames see it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_strobe | input | 1 | One-cycle pulse: a received identifier is present |
| rx_id | input | 29 | Received identifier; a standard identifier sits in bits [28:18] |
| rx_ext | input | 1 | 1 = extended frame, 0 = standard frame |
| id_wr_en | input | 1 | Write the code and kind of one entry |
| id_wr_idx | input | 4 | Entry number for the code write |
| id_wr_code | input | 29 | Acceptance code value |
| id_wr_ext | input | 1 | Kind bit of the entry (1 = extended) |
| msel_wr_en | input | 1 | Write the mask-select vector |
| msel_wr_vec | input | 16 | Bit n: mask register used by entry n |
| valid_wr_en | input | 1 | Write the valid vector |
| valid_wr_vec | input | 16 | Bit n: entry n takes part in filtering |
| mask_wr_en | input | 1 | Write one mask register |
| mask_wr_sel | input | 1 | Which mask register to write |
| mask_wr_val | input | 29 | Mask value (1 = don't care) |
| hit | output | 1 | A valid entry accepted the last strobed frame |
| hit_idx | output | 4 | Lowest accepting entry number, 0 on a miss |

## Verification
The hardest situation to reach from the ports is a tie in which a lower-numbered entry would win but must be passed over. The bench sets up two entries with the same code and kind, then removes the lower one through the valid vector alone. The same identifier must then resolve to the higher entry, and this is done at both ends of the index range (3/12 and 0/15). A register write landing in the same cycle as a strobe is also hard to produce. The bench drives both in a single cycle and then sends a second frame to show that the write only takes effect from then on. A mask-select change is also tested by showing that an identical frame moves from hit to miss.

// File: rtl/canrx_filt_pkg.sv
package canrx_filt_pkg;

    localparam int NBUF_DEF  = 16;
    localparam int ID_W_DEF  = 29;
    localparam int STD_W_DEF = 11;
    localparam int NMASK     = 2;

    typedef enum logic {
        KIND_STD = 1'b0,
        KIND_EXT = 1'b1
    } frame_kind_e;

    localparam logic MSEL_LOW  = 1'b0;
    localparam logic MSEL_HIGH = 1'b1;

endpackage

// File: rtl/canrx_filt_bank.sv
module canrx_filt_bank
    import canrx_filt_pkg::*;
#(
    parameter int NBUF  = NBUF_DEF,
    parameter int ID_W  = ID_W_DEF,
    parameter int IDX_W = $clog2(NBUF)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             id_wr_en,
    input  logic [IDX_W-1:0] id_wr_idx,
    input  logic [ID_W-1:0]  id_wr_code,
    input  logic             id_wr_ext,
    input  logic             msel_wr_en,
    input  logic [NBUF-1:0]  msel_wr_vec,
    input  logic             valid_wr_en,
    input  logic [NBUF-1:0]  valid_wr_vec,
    input  logic             mask_wr_en,
    input  logic             mask_wr_sel,
    input  logic [ID_W-1:0]  mask_wr_val,
    output logic [ID_W-1:0]  code_arr [NBUF],
    output logic [NBUF-1:0]  kind_vec,
    output logic [NBUF-1:0]  msel_vec,
    output logic [NBUF-1:0]  valid_vec,
    output logic [ID_W-1:0]  mask_arr [NMASK]
);

    // per-entry code and kind storage
    for (genvar g = 0; g < NBUF; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                code_arr[g] <= '0;
                kind_vec[g] <= KIND_STD;
            end else if (id_wr_en && (id_wr_idx == IDX_W'(g))) begin
                code_arr[g] <= id_wr_code;
                kind_vec[g] <= id_wr_ext;
            end
        end
    end

    // shared mask registers
    for (genvar m = 0; m < NMASK; m++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_arr[m] <= '0;
            end else if (mask_wr_en && (mask_wr_sel == 1'(m))) begin
                mask_arr[m] <= mask_wr_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msel_vec  <= {NBUF{MSEL_LOW}};
            valid_vec <= '0;
        end else begin
            if (msel_wr_en)  msel_vec  <= msel_wr_vec;
            if (valid_wr_en) valid_vec <= valid_wr_vec;
        end
    end

endmodule

// File: rtl/canrx_filt_match.sv
module canrx_filt_match
    import canrx_filt_pkg::*;
#(
    parameter int NBUF  = NBUF_DEF,
    parameter int ID_W  = ID_W_DEF,
    parameter int STD_W = STD_W_DEF
) (
    input  logic [ID_W-1:0] rx_id,
    input  logic            rx_ext,
    input  logic [ID_W-1:0] code_arr [NBUF],
    input  logic [NBUF-1:0] kind_vec,
    input  logic [NBUF-1:0] msel_vec,
    input  logic [NBUF-1:0] valid_vec,
    input  logic [ID_W-1:0] mask_arr [NMASK],
    output logic [NBUF-1:0] match_vec
);

    localparam logic [ID_W-1:0] EXT_WIN = '1;
    localparam logic [ID_W-1:0] STD_WIN = {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};

    logic [ID_W-1:0] window;
    assign window = (rx_ext == KIND_EXT) ? EXT_WIN : STD_WIN;

    for (genvar g = 0; g < NBUF; g++) begin : g_cmp
        logic [ID_W-1:0] sel_mask;
        logic [ID_W-1:0] care;
        logic            bits_ok;
        logic            kind_ok;

        always_comb begin
            sel_mask = (msel_vec[g] == MSEL_HIGH) ? mask_arr[1] : mask_arr[0];
            care     = ~sel_mask & window;
            bits_ok  = ((rx_id ^ code_arr[g]) & care) == '0;
            kind_ok  = (kind_vec[g] == rx_ext);
        end

        assign match_vec[g] = valid_vec[g] & kind_ok & bits_ok;
    end

endmodule

// File: rtl/canrx_low_pick.sv
module canrx_low_pick #(
    parameter int NBUF  = 16,
    parameter int IDX_W = $clog2(NBUF)
) (
    input  logic [NBUF-1:0]  req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // scan from the top down so the lowest request is the last one written
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NBUF - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/canrx_filter_select.sv
module canrx_filter_select
    import canrx_filt_pkg::*;
#(
    parameter int NBUF  = NBUF_DEF,
    parameter int ID_W  = ID_W_DEF,
    parameter int STD_W = STD_W_DEF,
    parameter int IDX_W = $clog2(NBUF)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_strobe,
    input  logic [ID_W-1:0]  rx_id,
    input  logic             rx_ext,
    input  logic             id_wr_en,
    input  logic [IDX_W-1:0] id_wr_idx,
    input  logic [ID_W-1:0]  id_wr_code,
    input  logic             id_wr_ext,
    input  logic             msel_wr_en,
    input  logic [NBUF-1:0]  msel_wr_vec,
    input  logic             valid_wr_en,
    input  logic [NBUF-1:0]  valid_wr_vec,
    input  logic             mask_wr_en,
    input  logic             mask_wr_sel,
    input  logic [ID_W-1:0]  mask_wr_val,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx
);

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    logic [ID_W-1:0] code_arr [NBUF];
    logic [NBUF-1:0] kind_vec;
    logic [NBUF-1:0] msel_vec;
    logic [NBUF-1:0] buf_valid;
    logic [ID_W-1:0] mask_arr [NMASK];
    logic [NBUF-1:0] match_vec;
    pick_t           pick_now;
    pick_t           pick_q;

    canrx_filt_bank #(.NBUF(NBUF), .ID_W(ID_W), .IDX_W(IDX_W)) u_bank (
        .clk          (clk),
        .rst          (rst),
        .id_wr_en     (id_wr_en),
        .id_wr_idx    (id_wr_idx),
        .id_wr_code   (id_wr_code),
        .id_wr_ext    (id_wr_ext),
        .msel_wr_en   (msel_wr_en),
        .msel_wr_vec  (msel_wr_vec),
        .valid_wr_en  (valid_wr_en),
        .valid_wr_vec (valid_wr_vec),
        .mask_wr_en   (mask_wr_en),
        .mask_wr_sel  (mask_wr_sel),
        .mask_wr_val  (mask_wr_val),
        .code_arr     (code_arr),
        .kind_vec     (kind_vec),
        .msel_vec     (msel_vec),
        .valid_vec    (buf_valid),
        .mask_arr     (mask_arr)
    );

    canrx_filt_match #(.NBUF(NBUF), .ID_W(ID_W), .STD_W(STD_W)) u_match (
        .rx_id     (rx_id),
        .rx_ext    (rx_ext),
        .code_arr  (code_arr),
        .kind_vec  (kind_vec),
        .msel_vec  (msel_vec),
        .valid_vec (buf_valid),
        .mask_arr  (mask_arr),
        .match_vec (match_vec)
    );

    canrx_low_pick #(.NBUF(NBUF), .IDX_W(IDX_W)) u_pick (
        .req   (match_vec),
        .found (pick_now.hit),
        .idx   (pick_now.idx)
    );

    // decision register: loaded only on a strobe, held otherwise
    always_ff @(posedge clk) begin
        if (rst) begin
            pick_q <= '0;
        end else if (rx_strobe) begin
            pick_q <= pick_now;
        end
    end

    assign hit     = pick_q.hit;
    assign hit_idx = pick_q.idx;

endmodule

// File: rtl/canrx_filter_select_chk.sv
module canrx_filter_select_chk #(
    parameter int NBUF  = 16,
    parameter int IDX_W = $clog2(NBUF)
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_strobe,
    input logic             hit,
    input logic [IDX_W-1:0] hit_idx,
    input logic [NBUF-1:0]  buf_valid,
    input logic [NBUF-1:0]  match_vec
);

    logic [NBUF-1:0] match_q;
    logic [NBUF-1:0] valid_q;
    logic [NBUF-1:0] below;

    always_ff @(posedge clk) begin
        match_q <= match_vec;
        valid_q <= buf_valid;
    end

    assign below = (NBUF'(1) << hit_idx) - NBUF'(1);

    // R1: reset clears the decision
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!hit && hit_idx == '0));

    // R5: comparator never flags an invalid entry
    a_r5_invalid_silent: assert property (@(posedge clk) disable iff (rst)
        (match_vec & ~buf_valid) == '0);

    // R5: a reported entry was valid when the frame was strobed
    a_r5_hit_was_valid: assert property (@(posedge clk) disable iff (rst)
        rx_strobe |=> (!hit || valid_q[hit_idx]));

    // R4: hit follows the match vector and reports its lowest set bit
    a_r4_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        rx_strobe |=> ((hit == (match_q != '0)) &&
                       (!hit || (match_q[hit_idx] && (match_q & below) == '0))));

    // R8: decision holds between strobes
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !rx_strobe |=> ($stable(hit) && $stable(hit_idx)));

    // R8: a miss reports index zero
    a_r8_miss_idx_zero: assert property (@(posedge clk) disable iff (rst)
        !hit |-> hit_idx == '0);

endmodule

bind canrx_filter_select canrx_filter_select_chk #(.NBUF(NBUF), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_strobe (rx_strobe),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .buf_valid (buf_valid),
    .match_vec (match_vec)
);

// File: tb/canrx_filter_select_test.sv
`timescale 1ns/1ps
module canrx_filter_select_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_strobe = 1'b0;
    logic [28:0] rx_id = '0;
    logic        rx_ext = 1'b0;
    logic        id_wr_en = 1'b0;
    logic [3:0]  id_wr_idx = '0;
    logic [28:0] id_wr_code = '0;
    logic        id_wr_ext = 1'b0;
    logic        msel_wr_en = 1'b0;
    logic [15:0] msel_wr_vec = '0;
    logic        valid_wr_en = 1'b0;
    logic [15:0] valid_wr_vec = '0;
    logic        mask_wr_en = 1'b0;
    logic        mask_wr_sel = 1'b0;
    logic [28:0] mask_wr_val = '0;
    logic        hit;
    logic [3:0]  hit_idx;

    always #5 clk = ~clk;

    canrx_filter_select uut (
        .clk(clk), .rst(rst), .rx_strobe(rx_strobe), .rx_id(rx_id), .rx_ext(rx_ext),
        .id_wr_en(id_wr_en), .id_wr_idx(id_wr_idx), .id_wr_code(id_wr_code),
        .id_wr_ext(id_wr_ext), .msel_wr_en(msel_wr_en), .msel_wr_vec(msel_wr_vec),
        .valid_wr_en(valid_wr_en), .valid_wr_vec(valid_wr_vec),
        .mask_wr_en(mask_wr_en), .mask_wr_sel(mask_wr_sel), .mask_wr_val(mask_wr_val),
        .hit(hit), .hit_idx(hit_idx)
    );

    typedef struct {
        bit       hit;
        bit [3:0] idx;
        string    req;
    } exp_t;

    exp_t        expq[$];
    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 0;
    logic [15:0] vmask  = '0;

    task automatic check(string req, bit act_h, bit [3:0] act_i, bit exp_h, bit [3:0] exp_i);
        n_chk++;
        if (act_h !== exp_h || act_i !== exp_i) begin
            n_fail++;
            $display("FAIL %s: hit/idx actual %0d/%0d expected %0d/%0d",
                     req, act_h, act_i, exp_h, exp_i);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // monitor: result is visible just after the edge that samples the strobe
    always @(posedge clk) begin
        if (!rst && rx_strobe === 1'b1) begin
            #2;
            if (expq.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R8: unexpected result hit/idx actual %0d/%0d expected none", hit, hit_idx);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(e.req, hit, hit_idx, e.hit, e.idx);
            end
        end
    end

    task automatic send(logic [28:0] id, bit ext, bit eh, bit [3:0] ei, string req);
        exp_t e;
        e.hit = eh; e.idx = ei; e.req = req;
        @(negedge clk);
        expq.push_back(e);
        rx_strobe = 1'b1; rx_id = id; rx_ext = ext;
        @(negedge clk);
        rx_strobe = 1'b0;
    endtask

    task automatic wr_id(int idx, logic [28:0] code, bit ext);
        @(negedge clk);
        id_wr_en = 1'b1; id_wr_idx = 4'(idx); id_wr_code = code; id_wr_ext = ext;
        @(negedge clk);
        id_wr_en = 1'b0;
    endtask

    task automatic wr_valid(logic [15:0] v);
        @(negedge clk);
        valid_wr_en = 1'b1; valid_wr_vec = v;
        @(negedge clk);
        valid_wr_en = 1'b0;
    endtask

    task automatic wr_msel(logic [15:0] v);
        @(negedge clk);
        msel_wr_en = 1'b1; msel_wr_vec = v;
        @(negedge clk);
        msel_wr_en = 1'b0;
    endtask

    task automatic wr_mask(bit sel, logic [28:0] v);
        @(negedge clk);
        mask_wr_en = 1'b1; mask_wr_sel = sel; mask_wr_val = v;
        @(negedge clk);
        mask_wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state", hit, hit_idx, 1'b0, 4'd0);
        // all entries invalid: code 0/std would match id 0 if valid
        send(29'h0, 1'b0, 1'b0, 4'd0, "R1 R5 all invalid after reset");

        // entry 5: standard code 0x123
        wr_id(5, {11'h123, 18'h0}, 1'b0);
        vmask[5] = 1'b1; wr_valid(vmask);
        send({11'h123, 18'h3ABCD}, 1'b0, 1'b1, 4'd5, "R7 standard low bits ignored");
        send({11'h123, 18'h3ABCD}, 1'b1, 1'b0, 4'd0, "R7 kind mismatch rejects");
        send({11'h122, 18'h0}, 1'b0, 1'b0, 4'd0, "R3 standard bit differs");

        // entry 2: extended code
        wr_id(2, 29'h1234567, 1'b1);
        vmask[2] = 1'b1; wr_valid(vmask);
        send(29'h1234567, 1'b1, 1'b1, 4'd2, "R7 extended exact hit");
        send(29'h1234566, 1'b1, 1'b0, 4'd0, "R3 extended low bit differs");

        // masks written while entries are invalid
        wr_valid(16'h0);
        wr_mask(1'b0, 29'h000000F);
        wr_mask(1'b1, 29'h0FFFFFFF);
        wr_valid(vmask);
        send(29'h1234560, 1'b1, 1'b1, 4'd2, "R2 masked bits ignored");

        // entry 9 uses mask register 1: only bit 28 compared
        wr_id(9, 29'h10000000, 1'b1);
        wr_msel(16'h0200);
        vmask[9] = 1'b1; wr_valid(vmask);
        send(29'h1ABCDEF0, 1'b1, 1'b1, 4'd9, "R6 entry uses mask register 1");
        wr_msel(16'h0000);
        send(29'h1ABCDEF0, 1'b1, 1'b0, 4'd0, "R6 back on mask register 0");

        // tie between entries 3 and 12
        wr_id(3, 29'h0AAAAAAA, 1'b1);
        wr_id(12, 29'h0AAAAAAA, 1'b1);
        vmask[3] = 1'b1; vmask[12] = 1'b1; wr_valid(vmask);
        send(29'h0AAAAAAA, 1'b1, 1'b1, 4'd3, "R4 lowest of 3 and 12");
        vmask[3] = 1'b0; wr_valid(vmask);
        send(29'h0AAAAAAA, 1'b1, 1'b1, 4'd12, "R4 R5 invalid 3 skipped");

        // tie at range ends 0 and 15
        wr_id(0, {11'h7FF, 18'h0}, 1'b0);
        wr_id(15, {11'h7FF, 18'h0}, 1'b0);
        vmask[0] = 1'b1; vmask[15] = 1'b1; wr_valid(vmask);
        send({11'h7FF, 18'h00055}, 1'b0, 1'b1, 4'd0, "R4 entry 0 wins over 15");
        vmask[0] = 1'b0; wr_valid(vmask);
        send({11'h7FF, 18'h00055}, 1'b0, 1'b1, 4'd15, "R4 entry 15 after 0 invalid");

        // hold: writes without strobe leave the result alone
        vmask[15] = 1'b0; wr_valid(vmask);
        wr_id(15, 29'h0, 1'b1);
        repeat (2) @(negedge clk);
        check("R8 result held between strobes", hit, hit_idx, 1'b1, 4'd15);

        // same-cycle write: valid cleared during the strobe
        @(negedge clk);
        expq.push_back('{hit: 1'b1, idx: 4'd5, req: "R9 same-cycle write not seen"});
        rx_strobe = 1'b1; rx_id = {11'h123, 18'h0}; rx_ext = 1'b0;
        valid_wr_en = 1'b1; valid_wr_vec = 16'h0;
        @(negedge clk);
        rx_strobe = 1'b0; valid_wr_en = 1'b0;
        send({11'h123, 18'h0}, 1'b0, 1'b0, 4'd0, "R9 write seen by next frame");

        repeat (3) @(negedge clk);
        if (expq.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R8: pending results actual %0d expected 0", expq.size());
        end
        finish_up();
    end

endmodule